// File: doc/BRIEF.md
# XY to Linear Destination Address Converter

This block keeps a destination coordinate register that holds a pixel column (X) and a row (Y). It turns that coordinate into a linear byte address for a drawing pipeline. A host writes the coordinate through a simple register write port that has byte enables. The write can reach the coordinate register through either of two equivalent addresses, so a command stream can burst through consecutive register locations. Any coordinate write that enables the most significant byte lane launches a conversion.

The conversion computes base + Y × pitch + X × bytes-per-pixel. The product Y × pitch comes from a shift-add multiplier that takes one cycle per coordinate bit. When it finishes, the sum is loaded into a separate linear destination register and a one-cycle done pulse is raised. The host may also write the linear register directly, byte by byte. A new trigger that arrives while a conversion is running abandons that conversion and starts again from the newest register contents. The base address, pitch and pixel size come from configuration inputs, which must stay stable while busy is high.

Top module: `xy_lin_conv`

## Requirements
- R1: After reset, xy_o, lin_o, busy_o and done_o are all zero.
- R2: A write to register address 0 updates only the bytes whose wr_be_i lane is set. X occupies xy_o bits CW-1:0 and Y occupies bits 16+CW-1:16.
- R3: Every xy_o bit outside the X and Y fields always reads zero, whatever data is written.
- R4: Register address 1 behaves exactly like address 0, for both storage and triggering.
- R5: A coordinate write with wr_be_i[3] set starts a conversion. A coordinate write without it never raises busy_o and never changes lin_o.
- R6: The converted value is (base_i + Y × pitch_i + (X << bpp_sel_i)) modulo 2^AW. bpp_sel_i values 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes per pixel.
- R7: busy_o is high from the cycle after the triggering edge until lin_o takes the result, which happens CW+1 clock edges after the trigger. done_o is high for exactly that one cycle, and busy_o is low in that cycle.
- R8: A write to register address 2 replaces the enabled low bytes of lin_o (AW/8 lanes) and leaves xy_o unchanged.
- R9: A trigger while busy_o is high restarts the conversion from the register contents after that write. Only one done pulse follows, CW+1 edges after the last trigger.
- R10: A write to register address 3 changes neither xy_o nor lin_o and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 coordinate, 1 coordinate alias, 2 linear, 3 unused |
| wr_be_i | input | 4 | Byte lane enables |
| wr_data_i | input | 32 | Write data |
| base_i | input | AW | Surface base address |
| pitch_i | input | PW | Bytes per row |
| bpp_sel_i | input | 2 | log2 of bytes per pixel |
| xy_o | output | 32 | Coordinate register readback |
| lin_o | output | AW | Linear destination register |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when lin_o takes a converted result |

## Verification
The bench builds the block with CW=4, PW=6 and AW=16. This shrinks the coordinate space to 16 × 16, so every X and Y pair can be converted at every pixel size and at several pitches, including pitch zero, and the multiplier runs only four steps. The narrow address makes the byte-lane merging of the linear register easy to see on both lanes. A four-bit coordinate leaves the top byte lane with no field bits, so a write that enables only the top byte acts as a pure restart trigger, and the bench uses that to check that a restart picks up the latest staged X.

// File: rtl/xy_lin_pkg.sv
package xy_lin_pkg;
  typedef enum logic [1:0] {
    REG_XY     = 2'd0,
    REG_XY_ALT = 2'd1,
    REG_LIN    = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned Y_LSB = 16;
endpackage

// File: rtl/xy_coord_reg.sv
module xy_coord_reg
  import xy_lin_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   data_i,
  output logic [31:0]   q_o,
  output logic [CW-1:0] x_nxt_o,
  output logic [CW-1:0] y_nxt_o
);
  localparam logic [31:0] FMASK = (32'((64'd1 << CW) - 1)) |
                                  (32'((64'd1 << CW) - 1) << Y_LSB);

  logic [31:0] q, d;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign d[8*b +: 8] = (wr_i && be_i[b]) ? (data_i[8*b +: 8] & FMASK[8*b +: 8])
                                           : q[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o     = q;
  assign x_nxt_o = d[CW-1:0];
  assign y_nxt_o = d[Y_LSB +: CW];

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~FMASK) == 32'd0);
  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/xy_lin_mul.sv
module xy_lin_mul #(
  parameter int unsigned CW = 11,
  parameter int unsigned PW = 16,
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] y_i,
  input  logic [PW-1:0] pitch_i,
  output logic [AW-1:0] prod_o,
  output logic          busy_o,
  output logic          valid_o
);
  localparam int unsigned CNTW = $clog2(CW + 1);

  logic [AW-1:0]   acc, pcur;
  logic [CW-1:0]   ysh;
  logic [CNTW-1:0] cnt;
  logic            busy, valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0; pcur <= '0; ysh <= '0; cnt <= '0; busy <= 1'b0; valid <= 1'b0;
    end else if (start_i) begin
      acc   <= '0;
      pcur  <= AW'(pitch_i);
      ysh   <= y_i;
      cnt   <= '0;
      busy  <= 1'b1;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (busy) begin
        if (ysh[0]) acc <= acc + pcur;
        ysh  <= ysh >> 1;
        pcur <= pcur << 1;
        cnt  <= cnt + 1'b1;
        if (cnt == CNTW'(CW - 1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign prod_o  = acc;
  assign busy_o  = busy;
  assign valid_o = valid;

  a_r9_mul_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || valid_o));
  a_r7_valid_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
endmodule

// File: rtl/xy_lin_conv.sv
module xy_lin_conv
  import xy_lin_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 11,
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [3:0]    wr_be_i,
  input  logic [31:0]   wr_data_i,
  input  logic [AW-1:0] base_i,
  input  logic [PW-1:0] pitch_i,
  input  logic [1:0]    bpp_sel_i,
  output logic [31:0]   xy_o,
  output logic [AW-1:0] lin_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned BW = AW / 8;

  reg_sel_e      sel;
  logic          xy_wr, lin_wr, trig, commit;
  logic [CW-1:0] x_nxt, y_nxt, x_snap;
  logic [AW-1:0] prod, result, lin_q;
  logic          mul_busy, mul_valid, busy_q, done_q;

  assign sel    = reg_sel_e'(wr_addr_i);
  assign xy_wr  = wr_en_i && (sel == REG_XY || sel == REG_XY_ALT);
  assign lin_wr = wr_en_i && (sel == REG_LIN);
  assign trig   = xy_wr && wr_be_i[3];
  // a fresh trigger wins over a finishing conversion
  assign commit = mul_valid && !trig;

  xy_coord_reg #(.CW(CW)) u_coord (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (xy_wr),
    .be_i    (wr_be_i),
    .data_i  (wr_data_i),
    .q_o     (xy_o),
    .x_nxt_o (x_nxt),
    .y_nxt_o (y_nxt)
  );

  xy_lin_mul #(.CW(CW), .PW(PW), .AW(AW)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (trig),
    .y_i     (y_nxt),
    .pitch_i (pitch_i),
    .prod_o  (prod),
    .busy_o  (mul_busy),
    .valid_o (mul_valid)
  );

  assign result = base_i + prod + (AW'(x_snap) << bpp_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_snap <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      if (trig) x_snap <= x_nxt;
      if (trig)        busy_q <= 1'b1;
      else if (commit) busy_q <= 1'b0;
      done_q <= commit;
    end
  end

  for (genvar b = 0; b < BW; b++) begin : g_lin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    lin_q[8*b +: 8] <= '0;
      else if (commit)                lin_q[8*b +: 8] <= result[8*b +: 8];
      else if (lin_wr && wr_be_i[b])  lin_q[8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  assign lin_o  = lin_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r5_busy_on_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> busy_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_lin_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == 2'd2) |=> ($stable(lin_o) || done_o));
  a_r7_mul_within_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_busy |-> busy_o);
endmodule

// File: tb/xy_lin_conv_tb.sv
`timescale 1ns/1ps
module xy_lin_conv_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned CW = 4;
  localparam int unsigned PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [3:0]    wr_be = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] base = '0;
  logic [PW-1:0] pitch = '0;
  logic [1:0]    bpp = '0;
  logic [31:0]   xy;
  logic [AW-1:0] lin;
  logic          busy, done;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xy_lin_conv #(.AW(AW), .CW(CW), .PW(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .base_i(base), .pitch_i(pitch),
    .bpp_sel_i(bpp), .xy_o(xy), .lin_o(lin), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  function automatic logic [AW-1:0] expect_lin(input int x, input int y);
    return AW'(int'(base) + y * int'(pitch) + (x << bpp));
  endfunction

  // called at the negedge right after the triggering edge
  task automatic wait_conv(input string req, input logic [AW-1:0] exp);
    chk({req, " busy after trigger"}, 32'(busy), 32'd1);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      chk({req, " no early done"}, 32'(done), 32'd0);
    end
    @(negedge clk);
    chk({req, " done pulse"}, 32'(done), 32'd1);
    chk({req, " busy cleared"}, 32'(busy), 32'd0);
    chk({req, " lin value"}, 32'(lin), 32'(exp));
    @(negedge clk);
    chk({req, " done one cycle"}, 32'(done), 32'd0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] lin_keep;
    logic [31:0]   xy_keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 xy", xy, 32'd0);
    chk("R1 lin", 32'(lin), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    base = 16'h1234; pitch = 6'd37;

    // R2 byte lanes, R3 reserved bits, R5 no trigger without top byte
    wr(2'd0, 32'hFFFF_FFFF, 4'b0001);
    chk("R2 low lane X", xy, 32'h0000_000F);
    chk("R5 no busy", 32'(busy), 32'd0);
    wr(2'd0, 32'h00AB_0000, 4'b0100);
    chk("R2 Y lane", xy, 32'h000B_000F);
    wr(2'd0, 32'hFFFF_FFFF, 4'b0110);
    chk("R3 reserved zero", xy, 32'h000F_000F);
    repeat (CW + 3) @(negedge clk);
    chk("R5 still idle", 32'(busy), 32'd0);
    chk("R5 lin unchanged", 32'(lin), 32'd0);

    // R10 address 3 ignored
    wr(2'd3, 32'h0005_0006, 4'b1111);
    chk("R10 xy unchanged", xy, 32'h000F_000F);
    chk("R10 no busy", 32'(busy), 32'd0);
    chk("R10 lin unchanged", 32'(lin), 32'd0);

    // R4 alias triggers and stores
    wr(2'd1, 32'h0003_0005, 4'b1111);
    chk("R4 alias store", xy, 32'h0003_0005);
    wait_conv("R4", expect_lin(5, 3));

    // R8 direct linear write
    xy_keep = xy;
    lin_keep = lin;
    wr(2'd2, 32'h0000_BEEF, 4'b0001);
    chk("R8 low byte", 32'(lin), {16'd0, lin_keep[15:8], 8'hEF});
    wr(2'd2, 32'h0000_BEEF, 4'b0010);
    chk("R8 high byte", 32'(lin), 32'h0000_BEEF);
    chk("R8 xy untouched", xy, xy_keep);
    chk("R8 no busy", 32'(busy), 32'd0);

    // R9 restart with full write via alias
    wr(2'd0, 32'h0007_0002, 4'b1111);
    @(negedge clk);
    wr(2'd1, 32'h000C_0009, 4'b1111);
    wait_conv("R9 restart", expect_lin(9, 12));

    // R9 restart picks up staged X from a non-trigger write during busy
    wr(2'd0, 32'h0005_0002, 4'b1111);
    wr(2'd0, 32'h0000_0009, 4'b0001);
    chk("R9 staged no restart busy", 32'(busy), 32'd1);
    wr(2'd0, 32'h0000_0000, 4'b1000);
    wait_conv("R9 latest", expect_lin(9, 5));

    // R6 sweep over every coordinate, pixel size and several pitches
    for (int p = 0; p < 3; p++) begin
      pitch = (p == 0) ? 6'd0 : (p == 1) ? 6'd37 : 6'd63;
      base  = (p == 2) ? 16'hFF80 : 16'h0100;
      for (int s = 0; s < 4; s++) begin
        bpp = 2'(s);
        for (int y = 0; y < 16; y++) begin
          for (int x = 0; x < 16; x++) begin
            wr(2'(x & 1), {12'd0, 4'(y), 12'd0, 4'(x)}, 4'b1111);
            wait_conv("R6 sweep", expect_lin(x, y));
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule